// File: doc/BRIEF.md
# Grounded-Neutral Oscillation Detector

This block watches the digital output of a comparator placed on the grounded-neutral sense node. The comparator pulses high each time the node swings above its threshold. When a neutral conductor is bonded to ground on the load side, the sense loop turns into an oscillator and the comparator toggles steadily. The block qualifies each pulse by its width and measures the spacing between rising edges. It confirms that a sustained oscillation is present, then runs a handshake with the sense amplifier. The amplifier is switched off for a fixed pause and switched back on. The block then watches whether the oscillation comes back. Only an oscillation that restarts by itself raises the fault. A short disturbance that dies during the pause does not.

A variant input selects how many off/on rounds must pass before the fault is declared: one round, or two. An enable input switches the whole detection function off. While it is low, all progress is cleared, the amplifier is held on and no flag is raised. Timing values are counted in clock cycles and set by parameters. The defaults are scaled down from the millisecond figures so that simulation stays short.

Top module: `gn_osc_detect`

## Requirements
- R1: During and right after reset, `amp_en` is 1, `gn_fault` is 0 and `freq_ok` is 0.
- R2: A comparator pulse counts as qualified only if it stays high for more than `MIN_HIGH` consecutive cycles. Pulses of `MIN_HIGH` cycles or fewer never advance detection.
- R3: At each rising edge of `gn_cmp`, `freq_ok` becomes 1 if the distance from the previous rising edge was between `MIN_PERIOD` and `MAX_PERIOD` cycles inclusive, and 0 otherwise. It becomes 0 once more than `MAX_PERIOD` cycles pass without a rising edge.
- R4: When qualified, in-range pulses are sustained for `CONFIRM` cycles, `amp_en` drops to 0 for exactly `PAUSE_LEN` cycles and then returns to 1.
- R5: If `RETURN_PULSES` qualified, in-range pulses arrive within `RECHECK_WIN` cycles of re-enable in the final round, `gn_fault` rises. It stays at 1 for as long as `det_en` is 1.
- R6: With `dual_pass` = 1, two complete pause/re-check rounds take place before `gn_fault` rises. With `dual_pass` = 0, one round suffices. In both cases the fault arrives within the bounded total time: `CONFIRM+PAUSE_LEN+RECHECK_WIN+2*MAX_PERIOD` cycles from the first rising edge for one round, and `2*(CONFIRM+PAUSE_LEN+RECHECK_WIN)+2*MAX_PERIOD` cycles for two.
- R7: If the oscillation does not return within `RECHECK_WIN` cycles after re-enable, the block goes back to idle with `gn_fault` at 0 and `amp_en` at 1.
- R8: While presence is being confirmed, a gap of `MAX_PERIOD` cycles or more without a qualified pulse clears the progress. A later burst needs a full `CONFIRM` again.
- R9: While `det_en` is 0, from the next cycle on, `gn_fault` is 0, `amp_en` is 1 and `freq_ok` is 0, whatever `gn_cmp` does.
- R10: `amp_en` is 0 only during the pause. It is 1 whenever `gn_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gn_cmp | input | 1 | Comparator output, high while the sense node is above threshold |
| det_en | input | 1 | 1 enables detection, 0 disables and clears it |
| dual_pass | input | 1 | 1 requires two pause/re-check rounds before the fault |
| amp_en | output | 1 | Sense amplifier enable |
| gn_fault | output | 1 | Grounded-neutral fault, sticky while enabled |
| freq_ok | output | 1 | Last measured edge spacing was within the valid range |

## Verification
The assertions take for granted that `gn_cmp` is already synchronous to `clk`. They also assume the comparator can only toggle while the amplifier is on. The bench honours both: it drives `gn_cmp` on the falling edge, and it gates every pulse with the `amp_en` it observes, so the comparator stays low through each pause. `dual_pass` is only changed while detection is idle or disabled. Under these conditions the pause-length bound and the rule that every fault is preceded by a pause hold by construction of the stimulus, not by luck.

// File: rtl/gn_pkg.sv
// Shared types for the grounded-neutral oscillation detector.
package gn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARM     = 3'd1,
        ST_PAUSE   = 3'd2,
        ST_RECHECK = 3'd3,
        ST_FAULT   = 3'd4
    } gn_state_t;
endpackage

// File: rtl/gn_pulse_meter.sv
// Pulse meter: qualifies comparator pulses by width and measures the
// spacing of rising edges.
// Outputs:
//   good/bad - one-cycle strobes for a qualified pulse, split by whether
//              its period was in range
//   lost     - level, high when no qualified pulse was seen for MAX_PERIOD
//              cycles
//   freq_ok  - registered in-range flag
// Assumes cmp is synchronous to clk. clr acts as a synchronous clear.
module gn_pulse_meter #(
    parameter int MIN_HIGH   = 3,
    parameter int MIN_PERIOD = 16,
    parameter int MAX_PERIOD = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cmp,
    output logic good,
    output logic bad,
    output logic lost,
    output logic freq_ok
);
    localparam int HW = $clog2(MIN_HIGH + 2);
    localparam int PW = $clog2(MAX_PERIOD + 2);
    localparam logic [HW-1:0] HI_QUAL = HW'(MIN_HIGH);
    localparam logic [HW-1:0] HI_SAT  = HW'(MIN_HIGH + 1);
    localparam logic [PW-1:0] P_LO    = PW'(MIN_PERIOD);
    localparam logic [PW-1:0] P_HI    = PW'(MAX_PERIOD);
    localparam logic [PW-1:0] P_SAT   = PW'(MAX_PERIOD + 1);

    logic [HW-1:0] hi_cnt;
    logic [PW-1:0] per_cnt;
    logic [PW-1:0] since_q;
    logic          cmp_q;
    logic          have_edge;
    logic          fok_q;
    logic          rise;
    logic          qual;

    assign rise    = cmp && !cmp_q;
    assign qual    = cmp && (hi_cnt == HI_QUAL);
    assign good    = qual && fok_q;
    assign bad     = qual && !fok_q;
    assign lost    = (since_q >= P_HI);
    assign freq_ok = fok_q;

    // Count consecutive high cycles, saturating one past the qualify point.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   hi_cnt <= '0;
        else if (!cmp)       hi_cnt <= '0;
        else if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
    end

    // Measure rising-edge spacing and judge it against the valid window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cmp_q     <= 1'b0;
            per_cnt   <= '0;
            have_edge <= 1'b0;
            fok_q     <= 1'b0;
        end else begin
            cmp_q <= cmp;
            if (rise) begin
                fok_q     <= have_edge && (per_cnt >= P_LO) && (per_cnt <= P_HI);
                per_cnt   <= PW'(1);
                have_edge <= 1'b1;
            end else if (per_cnt == P_SAT) begin
                fok_q     <= 1'b0;
                have_edge <= 1'b0;
            end else begin
                per_cnt <= per_cnt + 1'b1;
            end
        end
    end

    // Track cycles since the last qualified pulse, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      since_q <= '0;
        else if (qual)          since_q <= '0;
        else if (since_q != P_HI) since_q <= since_q + 1'b1;
    end
endmodule

// File: rtl/gn_seq_fsm.sv
// Sequencer: confirms a sustained oscillation, pauses the amplifier,
// re-checks after re-enable and latches the fault.
// Runs one round, or two when dual_pass is high.
// Assumes good/bad/lost come from gn_pulse_meter on the same clock.
module gn_seq_fsm
    import gn_pkg::*;
#(
    parameter int CONFIRM       = 200,
    parameter int PAUSE_LEN     = 120,
    parameter int RECHECK_WIN   = 150,
    parameter int RETURN_PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic dual_pass,
    input  logic good,
    input  logic bad,
    input  logic lost,
    output logic amp_en,
    output logic fault
);
    localparam int T_AB  = (CONFIRM > PAUSE_LEN) ? CONFIRM : PAUSE_LEN;
    localparam int T_MAX = (T_AB > RECHECK_WIN) ? T_AB : RECHECK_WIN;
    localparam int TW    = $clog2(T_MAX + 1);
    localparam int NW    = $clog2(RETURN_PULSES + 1);
    localparam logic [TW-1:0] T_CONF  = TW'(CONFIRM - 1);
    localparam logic [TW-1:0] T_PAUSE = TW'(PAUSE_LEN - 1);
    localparam logic [TW-1:0] T_WIN   = TW'(RECHECK_WIN - 1);
    localparam logic [NW-1:0] N_LAST  = NW'(RETURN_PULSES - 1);

    gn_state_t     state;
    logic [TW-1:0] tmr;
    logic [NW-1:0] npulse;
    logic          round;

    assign amp_en = (state != ST_PAUSE);
    assign fault  = (state == ST_FAULT);

    // Advance the detection sequence one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state  <= ST_IDLE;
            tmr    <= '0;
            npulse <= '0;
            round  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    round <= 1'b0;
                    if (good) begin
                        state <= ST_ARM;
                        tmr   <= '0;
                    end
                end
                ST_ARM: begin
                    if (bad || lost) begin
                        state <= ST_IDLE;
                        round <= 1'b0;
                    end else if (tmr == T_CONF) begin
                        state <= ST_PAUSE;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_PAUSE: begin
                    if (tmr == T_PAUSE) begin
                        state  <= ST_RECHECK;
                        tmr    <= '0;
                        npulse <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_RECHECK: begin
                    tmr <= tmr + 1'b1;
                    if (good) begin
                        if (npulse == N_LAST) begin
                            if (dual_pass && !round) begin
                                state <= ST_ARM;
                                round <= 1'b1;
                                tmr   <= '0;
                            end else begin
                                state <= ST_FAULT;
                            end
                        end else begin
                            npulse <= npulse + 1'b1;
                        end
                    end else if (tmr == T_WIN) begin
                        state <= ST_IDLE;
                        round <= 1'b0;
                    end
                end
                ST_FAULT: state <= ST_FAULT;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gn_osc_detect.sv
// Top of the grounded-neutral oscillation detector.
// Chains the pulse meter into the sequencer. det_en low clears both
// synchronously.
// Assumes gn_cmp is already synchronous to clk.
module gn_osc_detect #(
    parameter int MIN_HIGH      = 3,
    parameter int MIN_PERIOD    = 16,
    parameter int MAX_PERIOD    = 56,
    parameter int CONFIRM       = 200,
    parameter int PAUSE_LEN     = 120,
    parameter int RECHECK_WIN   = 150,
    parameter int RETURN_PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gn_cmp,
    input  logic det_en,
    input  logic dual_pass,
    output logic amp_en,
    output logic gn_fault,
    output logic freq_ok
);
    logic clr;
    logic good;
    logic bad;
    logic lost;

    assign clr = !det_en;

    gn_pulse_meter #(
        .MIN_HIGH   (MIN_HIGH),
        .MIN_PERIOD (MIN_PERIOD),
        .MAX_PERIOD (MAX_PERIOD)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .cmp     (gn_cmp),
        .good    (good),
        .bad     (bad),
        .lost    (lost),
        .freq_ok (freq_ok)
    );

    gn_seq_fsm #(
        .CONFIRM       (CONFIRM),
        .PAUSE_LEN     (PAUSE_LEN),
        .RECHECK_WIN   (RECHECK_WIN),
        .RETURN_PULSES (RETURN_PULSES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .dual_pass (dual_pass),
        .good      (good),
        .bad       (bad),
        .lost      (lost),
        .amp_en    (amp_en),
        .fault     (gn_fault)
    );
endmodule

// File: rtl/gn_osc_detect_chk.sv
// Port-level checker for gn_osc_detect, attached by bind.
// Assumes gn_cmp only toggles while amp_en is high.
module gn_osc_detect_chk #(
    parameter int PAUSE_LEN = 120
) (
    input logic clk,
    input logic rst_n,
    input logic gn_cmp,
    input logic det_en,
    input logic amp_en,
    input logic gn_fault,
    input logic freq_ok
);
    int unsigned lo_run;
    logic        seen_pause;

    // Length of the current amplifier-off run.
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_run <= 0;
        else if (!amp_en) lo_run <= lo_run + 1;
        else              lo_run <= 0;
    end

    // Remember that a pause happened since detection was last enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !det_en) seen_pause <= 1'b0;
        else if (!amp_en)      seen_pause <= 1'b1;
    end

    a_r4_pause_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        lo_run <= PAUSE_LEN);

    a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (gn_fault && det_en) |=> gn_fault);

    a_r6_fault_after_pause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gn_fault) |-> seen_pause);

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> (!gn_fault && amp_en && !freq_ok));

    a_r10_amp_on_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        gn_fault |-> amp_en);

    a_r3_freq_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freq_ok) |-> ($past(gn_cmp) && !$past(gn_cmp, 2)));
endmodule

bind gn_osc_detect gn_osc_detect_chk #(.PAUSE_LEN(PAUSE_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gn_cmp   (gn_cmp),
    .det_en   (det_en),
    .amp_en   (amp_en),
    .gn_fault (gn_fault),
    .freq_ok  (freq_ok)
);

// File: tb/test_gn_osc_detect.sv
module test_gn_osc_detect;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_HIGH = 3, MIN_PERIOD = 16, MAX_PERIOD = 56;
    localparam int CONFIRM = 200, PAUSE_LEN = 120, RECHECK_WIN = 150, RETURN_PULSES = 3;
    localparam int BOUND1 = CONFIRM + PAUSE_LEN + RECHECK_WIN + 2*MAX_PERIOD;
    localparam int BOUND2 = 2*(CONFIRM + PAUSE_LEN + RECHECK_WIN) + 2*MAX_PERIOD;

    logic clk = 1'b0, rst_n = 1'b0, gn_cmp = 1'b0, det_en = 1'b1, dual_pass = 1'b0;
    logic amp_en, gn_fault, freq_ok;

    gn_osc_detect i_gn_osc_detect (
        .clk(clk), .rst_n(rst_n), .gn_cmp(gn_cmp), .det_en(det_en),
        .dual_pass(dual_pass), .amp_en(amp_en), .gn_fault(gn_fault), .freq_ok(freq_ok));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0, started = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model: integers, updated at each rising edge.
    int m_hi, m_per, m_since, m_st, m_tmr, m_np, m_round;
    bit m_cq, m_have, m_fok;
    bit e_rise, e_qual, e_good, e_bad, e_lost, c_in;
    always @(posedge clk) begin
        c_in = gn_cmp;
        if (!rst_n || !det_en) begin
            m_hi = 0; m_per = 0; m_since = 0; m_st = 0; m_tmr = 0; m_np = 0; m_round = 0;
            m_cq = 0; m_have = 0; m_fok = 0;
        end else begin
            e_rise = c_in && !m_cq;
            e_qual = c_in && (m_hi == MIN_HIGH);
            e_good = e_qual && m_fok;
            e_bad  = e_qual && !m_fok;
            e_lost = (m_since >= MAX_PERIOD);
            m_hi = c_in ? ((m_hi < MIN_HIGH + 1) ? m_hi + 1 : m_hi) : 0;
            m_cq = c_in;
            if (e_rise) begin
                m_fok = m_have && (m_per >= MIN_PERIOD) && (m_per <= MAX_PERIOD);
                m_per = 1; m_have = 1;
            end else if (m_per == MAX_PERIOD + 1) begin
                m_fok = 0; m_have = 0;
            end else m_per++;
            if (e_qual) m_since = 0;
            else if (m_since < MAX_PERIOD) m_since++;
            case (m_st)
                0: begin m_round = 0; if (e_good) begin m_st = 1; m_tmr = 0; end end
                1: if (e_bad || e_lost) begin m_st = 0; m_round = 0; end
                   else if (m_tmr == CONFIRM - 1) begin m_st = 2; m_tmr = 0; end
                   else m_tmr++;
                2: if (m_tmr == PAUSE_LEN - 1) begin m_st = 3; m_tmr = 0; m_np = 0; end
                   else m_tmr++;
                3: begin
                    m_tmr++;
                    if (e_good) begin
                        if (m_np == RETURN_PULSES - 1) begin
                            if (dual_pass && m_round == 0) begin m_st = 1; m_round = 1; m_tmr = 0; end
                            else m_st = 4;
                        end else m_np++;
                    end else if (m_tmr == RECHECK_WIN) begin m_st = 0; m_round = 0; end
                end
                default: m_st = 4;
            endcase
        end
        started = 1;
    end

    // Compare against the model every cycle, away from the active edge (R4 R5 R3).
    always @(negedge clk) if (started && !done) begin
        check(amp_en === (m_st != 2), "R4", "amp_en vs model", int'(amp_en), int'(m_st != 2));
        check(gn_fault === (m_st == 4), "R5", "gn_fault vs model", int'(gn_fault), int'(m_st == 4));
        check(freq_ok === m_fok, "R3", "freq_ok vs model", int'(freq_ok), int'(m_fok));
    end

    // Port monitor: pause count, last pause length, first fault cycle.
    int cyc = 0, lo_run = 0, n_pause = 0, last_pause = 0, fault_cyc = -1;
    always @(negedge clk) begin
        cyc++;
        if (!amp_en) lo_run++;
        else if (lo_run > 0) begin last_pause = lo_run; n_pause++; lo_run = 0; end
        if (gn_fault && fault_cyc < 0) fault_cyc = cyc;
    end

    task automatic clr_mon();
        @(posedge clk);
        lo_run = 0; n_pause = 0; last_pause = 0; fault_cyc = -1;
    endtask

    // Pulse train; the comparator is gated by the amplifier enable it sees.
    task automatic osc(input int n, input int per, input int hi, input bit stop_on_pause);
        bit stopped = 0;
        for (int p = 0; p < n; p++)
            for (int c = 0; c < per; c++) begin
                @(negedge clk);
                if (!amp_en && stop_on_pause) stopped = 1;
                gn_cmp = !stopped && amp_en && (c < hi);
            end
    endtask

    task automatic quiet(input int n);
        repeat (n) begin @(negedge clk); gn_cmp = 1'b0; end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    int t0;
    initial begin
        repeat (3) @(negedge clk);
        check(amp_en === 1'b1, "R1", "amp_en in reset", int'(amp_en), 1);
        check(gn_fault === 1'b0, "R1", "gn_fault in reset", int'(gn_fault), 0);
        check(freq_ok === 1'b0, "R1", "freq_ok in reset", int'(freq_ok), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(amp_en === 1'b1 && gn_fault === 1'b0, "R1", "outputs after reset", int'(gn_fault), 0);

        // R2: pulses only MIN_HIGH wide never qualify; R3: their spacing is in range
        clr_mon();
        osc(20, 30, MIN_HIGH, 0);
        check(n_pause == 0, "R2", "pauses with narrow pulses", n_pause, 0);
        check(freq_ok === 1'b1, "R3", "freq_ok at period 30", int'(freq_ok), 1);
        quiet(70);
        check(freq_ok === 1'b0, "R3", "freq_ok after long gap", int'(freq_ok), 0);

        // R3: too fast (period 10 < MIN_PERIOD) is out of range, no progress
        clr_mon();
        osc(30, 10, 4, 0);
        check(freq_ok === 1'b0, "R3", "freq_ok at period 10", int'(freq_ok), 0);
        check(n_pause == 0, "R3", "pauses at too-fast rate", n_pause, 0);
        quiet(70);

        // R4 R5 R6: single round leads to fault
        clr_mon(); t0 = cyc;
        osc(24, 30, 4, 0);
        check(n_pause == 1, "R6", "pause rounds single", n_pause, 1);
        check(last_pause == PAUSE_LEN, "R4", "pause length", last_pause, PAUSE_LEN);
        check(gn_fault === 1'b1, "R5", "fault after return", int'(gn_fault), 1);
        check(fault_cyc >= 0 && fault_cyc - t0 <= BOUND1, "R6", "single-round time", fault_cyc - t0, BOUND1);
        quiet(200);
        check(gn_fault === 1'b1, "R5", "fault sticky", int'(gn_fault), 1);
        check(amp_en === 1'b1, "R10", "amp on in fault", int'(amp_en), 1);

        // R9: disable clears and blocks detection
        det_en = 1'b0;
        quiet(2);
        check(gn_fault === 1'b0 && amp_en === 1'b1, "R9", "fault cleared by disable", int'(gn_fault), 0);
        clr_mon();
        osc(20, 30, 4, 0);
        check(n_pause == 0, "R9", "pauses while disabled", n_pause, 0);
        check(freq_ok === 1'b0, "R9", "freq_ok while disabled", int'(freq_ok), 0);
        det_en = 1'b1;
        quiet(70);

        // R6: dual round
        dual_pass = 1'b1;
        clr_mon(); t0 = cyc;
        osc(40, 30, 4, 0);
        check(n_pause == 2, "R6", "pause rounds dual", n_pause, 2);
        check(gn_fault === 1'b1, "R6", "fault after dual", int'(gn_fault), 1);
        check(fault_cyc >= 0 && fault_cyc - t0 <= BOUND2, "R6", "dual-round time", fault_cyc - t0, BOUND2);
        det_en = 1'b0; quiet(2); dual_pass = 1'b0; det_en = 1'b1; quiet(70);

        // R7: oscillation stops at the pause and never returns
        clr_mon();
        osc(30, 30, 4, 1);
        quiet(300);
        check(n_pause == 1, "R7", "one pause then silence", n_pause, 1);
        check(gn_fault === 1'b0, "R7", "no fault without return", int'(gn_fault), 0);
        check(amp_en === 1'b1, "R7", "amp on after give-up", int'(amp_en), 1);

        // R8: bursts shorter than CONFIRM separated by gaps never accumulate
        clr_mon();
        for (int b = 0; b < 4; b++) begin osc(4, 30, 4, 0); quiet(100); end
        check(n_pause == 0, "R8", "pauses after gapped bursts", n_pause, 0);
        check(gn_fault === 1'b0, "R8", "fault after gapped bursts", int'(gn_fault), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule